// File: doc/BRIEF.md
# Carrier-Modulated Manchester Infrared Frame Sender

This block sends one fixed-length frame over an infrared emitter pin. A frame is 64 bits wide. Its upper 16 bits are always ones and act as a sync header. The lower 48 bits come from the `data_i` port and are captured when the frame launches. The frame is sent most significant bit first. Each bit is Manchester coded as two equal halves. Whenever a half is active, it is filled with a square carrier at about 36 kHz, so a demodulating receiver sees a clean Manchester stream.

A frame launches in one of two ways. A single-cycle strobe can start it. When the repeat enable is held high, an internal timer also re-launches the frame at a fixed period. All timing is set by parameters counted in system-clock cycles: the carrier period, the half-bit length (nominally 889 us) and the repeat period (nominally 300 ms). Every counter runs from the one system clock. A busy flag covers the whole frame.

Top module: `ir_manchester_tx`

## Requirements
- R1: After reset, `ir_o` and `busy_o` are both low.
- R2: While `busy_o` is low, `ir_o` is low.
- R3: The first 16 bits of every frame are ones, whatever `data_i` holds.
- R4: The remaining 48 bits are `data_i` as sampled at launch, sent most significant bit first (`data_i[47]` first, `data_i[0]` last).
- R5: Manchester encoding: a 1 is inactive in its first half and active in its second half. A 0 is active in its first half and inactive in its second half.
- R6: Inside an active half, `ir_o` is high for the first `CARRIER_CYC/2` cycles of each `CARRIER_CYC`-cycle carrier period and low for the rest. The carrier phase is counted from the first cycle of the frame.
- R7: `busy_o` rises in the cycle after the launching clock edge and stays high for exactly `64*2*HALF_CYC` cycles. Each half lasts `HALF_CYC` cycles.
- R8: A strobe on `start_i` while `busy_o` is high is ignored. The running frame is unchanged and no new frame follows it.
- R9: While `repeat_en_i` is high, a new frame launches `REPEAT_CYC` cycles after the previous launch, carrying the `data_i` value present at that moment.
- R10: While `repeat_en_i` is low, no frame launches without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle launch strobe |
| data_i | input | 48 | Payload below the header |
| repeat_en_i | input | 1 | Enables periodic re-sending |
| ir_o | output | 1 | Carrier-modulated emitter drive |
| busy_o | output | 1 | High while a frame is on the pin |

## Verification
The waveform is compared cycle by cycle against a model computed in the bench. Three data patterns are run: all zeros, all ones and alternating bits. All zeros separates the forced header from the payload. All ones and alternating bits expose reversed Manchester halves and wrong bit order. Seeded random payloads, with a strobe injected at a random point mid-frame, catch carrier-phase and shift errors and show whether a busy strobe disturbs the frame. The repeat tests measure the launch-to-launch distance, change `data_i` between frames, and then confirm that the pin stays silent once repeat is disabled.

// File: rtl/ir_manchester_tx.sv
module ir_manchester_tx #(
  parameter int FRAME_W     = 64,
  parameter int HEAD_W      = 16,
  parameter int CARRIER_CYC = 3472,
  parameter int HALF_CYC    = 111125,
  parameter int REPEAT_CYC  = 37500000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [FRAME_W-HEAD_W-1:0]   data_i,
  input  logic                        repeat_en_i,
  output logic                        ir_o,
  output logic                        busy_o
);
  localparam int CAR_W  = $clog2(CARRIER_CYC + 1);
  localparam int CAR_HI = CARRIER_CYC / 2;
  localparam int HALF_W = $clog2(HALF_CYC + 1);
  localparam int BIT_W  = $clog2(FRAME_W);
  localparam int REP_W  = $clog2(REPEAT_CYC + 1);

  logic [FRAME_W-1:0] shreg;
  logic [CAR_W-1:0]   car_cnt;
  logic [HALF_W-1:0]  half_cnt;
  logic [BIT_W-1:0]   bit_cnt;
  logic [REP_W-1:0]   rep_cnt;
  logic               phase;
  logic               busy;

  wire rep_tick = repeat_en_i && (rep_cnt == REP_W'(REPEAT_CYC - 1));
  wire launch   = !busy && (start_i || rep_tick);
  wire half_end = (half_cnt == HALF_W'(HALF_CYC - 1));
  wire bit_last = (bit_cnt == BIT_W'(FRAME_W - 1));
  wire cur_bit  = shreg[FRAME_W-1];
  wire active   = phase ? cur_bit : ~cur_bit;
  wire car_on   = (car_cnt < CAR_W'(CAR_HI));

  assign busy_o = busy;
  assign ir_o   = busy & active & car_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      shreg    <= '0;
      car_cnt  <= '0;
      half_cnt <= '0;
      bit_cnt  <= '0;
      phase    <= 1'b0;
    end else if (launch) begin
      busy     <= 1'b1;
      shreg    <= {{HEAD_W{1'b1}}, data_i};
      car_cnt  <= '0;
      half_cnt <= '0;
      bit_cnt  <= '0;
      phase    <= 1'b0;
    end else if (busy) begin
      car_cnt <= (car_cnt == CAR_W'(CARRIER_CYC - 1)) ? '0 : car_cnt + 1'b1;
      if (half_end) begin
        half_cnt <= '0;
        phase    <= ~phase;
        if (phase) begin
          shreg   <= {shreg[FRAME_W-2:0], 1'b0};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_last) busy <= 1'b0;
        end
      end else begin
        half_cnt <= half_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rep_cnt <= '0;
    else if (launch)       rep_cnt <= '0;
    else if (!repeat_en_i) rep_cnt <= '0;
    else if (!rep_tick)    rep_cnt <= rep_cnt + 1'b1;
  end

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !ir_o);

  p_header_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (shreg[FRAME_W-1:FRAME_W-HEAD_W] == {HEAD_W{1'b1}}));

  p_frame_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && half_end && phase && bit_last) |=> !busy_o);

  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (!busy_o || (bit_cnt >= $past(bit_cnt))));

  p_repeat_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rep_tick |-> !busy_o);

  p_no_self_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i && !repeat_en_i) |=> !busy_o);
endmodule

// File: tb/ir_manchester_tx_tb.sv
module ir_manchester_tx_tb;
  localparam int CAR    = 6;
  localparam int HALF   = 18;
  localparam int REP    = 2600;
  localparam int FRAMEC = 128 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [47:0] data_i = '0;
  logic        repeat_en_i = 1'b0;
  logic        ir_o, busy_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ir_manchester_tx #(.CARRIER_CYC(CAR), .HALF_CYC(HALF), .REPEAT_CYC(REP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i),
    .repeat_en_i(repeat_en_i), .ir_o(ir_o), .busy_o(busy_o));

  function automatic logic exp_ir(input logic [47:0] d, input int k);
    logic [63:0] w;
    int b, ph;
    logic bv, act;
    w   = {16'hFFFF, d};
    b   = k / (2 * HALF);
    ph  = (k / HALF) % 2;
    bv  = w[63 - b];
    act = ph ? bv : !bv;
    return act && ((k % CAR) < CAR / 2);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Called at the negedge right after the launch edge (k = 0).
  task automatic check_frame(input logic [47:0] d, input int inject_at);
    int bad = 0, first = -1, busy_bad = 0;
    for (int k = 0; k < FRAMEC; k++) begin
      if (ir_o !== exp_ir(d, k)) begin
        bad++;
        if (first < 0) first = k;
      end
      if (busy_o !== 1'b1) busy_bad++;
      if (k == inject_at) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    check(bad == 0, "R3/R4/R5/R6 waveform mismatches (first at cycle shown as actual)", first, -1);
    check(busy_bad == 0 && busy_o === 1'b0, "R7 busy length", busy_bad, 0);
  endtask

  task automatic launch(input logic [47:0] d);
    @(negedge clk);
    data_i = d;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R7 busy rises after launch edge", busy_o, 1);
  endtask

  task automatic check_quiet(input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (busy_o !== 1'b0 || ir_o !== 1'b0) bad++;
      @(negedge clk);
    end
    check(bad == 0, req, bad, 0);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    logic [47:0] d;
    seed = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    check(busy_o === 1'b0 && ir_o === 1'b0, "R1 reset state", {busy_o, ir_o}, 0);
    rst_n = 1'b1;
    check_quiet(50, "R2 idle output low");

    launch(48'h0);              check_frame(48'h0, -1);
    check_quiet(40, "R2/R8 quiet after frame");
    launch(48'hFFFF_FFFF_FFFF); check_frame(48'hFFFF_FFFF_FFFF, -1);
    launch(48'hAAAA_5555_A5A5); check_frame(48'hAAAA_5555_A5A5, 0);
    check_quiet(40, "R8 strobe in first cycle ignored");

    for (int i = 0; i < 5; i++) begin
      d = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      launch(d);
      check_frame(d, int'($urandom % FRAMEC));
      check_quiet(20, "R8 no frame after busy strobe");
    end

    repeat_en_i = 1'b1;
    d = 48'h1234_5678_9ABC;
    launch(d);
    for (int r = 0; r < 3; r++) begin
      int gap;
      check_frame(d, -1);
      gap = FRAMEC;
      d = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      data_i = d;
      while (busy_o !== 1'b1 && gap < 4 * REP) begin
        @(negedge clk);
        gap++;
      end
      check(gap == REP, "R9 repeat period", gap, REP);
    end
    check_frame(d, -1);
    repeat_en_i = 1'b0;
    check_quiet(REP + 200, "R10 no self launch when disabled");
    finish_run();
  end
endmodule